// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a slow 32.768 kHz tick into a programmable periodic event for a real-time-clock style interrupt unit. A 15-bit phase counter advances by one on every tick and is never cleared outside reset. A 4-bit rate selector picks a power-of-two period, and an enable input gates the output. When the counter lands on a multiple of the selected period, the block emits a one-clock strobe that the flag and interrupt logic downstream consume.

Events are locked to the free-running phase, not to the moment software changes the settings. After an enable or rate change, the first event comes at the next multiple of the new period. It does not come a full period after the write. Both rate and enable are read at each tick, so a change acts from the next tick on. Because every event needs an exact phase alignment, a change never produces an extra event.

Top module: `periodic_rate_gen`

## Requirements
- R1: While reset is asserted, and immediately after it, `rate_evt` is 0 and the phase counter is 0. With selector 4 enabled from reset, the first strobe follows the 8th tick.
- R2: A `rate_sel` of 0 never produces a strobe, whatever the state of `rate_en`.
- R3: While `rate_en` is 0, no strobe is produced for any `rate_sel`.
- R4: For a `rate_sel` value n in 1..15 with `rate_en` at 1, the period is 2^(n-1) ticks. A strobe follows exactly those ticks that bring the phase count to a multiple of 2^(n-1).
- R5: `rate_evt` goes high only in the clock cycle after a clock edge at which `tick_32k` was sampled high, and it lasts one cycle per event.
- R6: When the block is enabled part-way through a period, the first strobe follows the next tick that makes the free-running phase a multiple of the period. The time of the enabling change does not affect it.
- R7: A change of `rate_sel` or `rate_en` is applied at the next tick. The comparison at that tick uses the new values, and no extra strobe results.
- R8: With `rate_sel` = 1, every tick produces a strobe.
- R9: The phase counter is 15 bits wide and wraps from 32767 to 0. With `rate_sel` = 15 (period 16384 ticks), strobes follow the ticks that reach phase 16384 and phase 0 after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz period |
| rate_sel | input | 4 | Rate code; 0 is off, n gives a period of 2^(n-1) ticks |
| rate_en | input | 1 | Periodic event enable |
| rate_evt | output | 1 | One-cycle event strobe |

## Verification
The bound checker covers the properties that hold at every single edge. A strobe always follows a tick and never follows a zero selector or a low enable. A strobe always falls on a phase that is aligned to the rate selected at that tick. The counter steps by exactly one on a tick and holds otherwise. Exact event spacing, the first event after reset, alignment after enabling mid-period, rate changes and the 15-bit wrap all depend on sequences of many ticks, so only the bench scenarios show them. The bench compares every cycle's output against a reference phase model.

// File: rtl/periodic_rate_gen.sv
`timescale 1ns/1ps
module periodic_rate_gen #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              rate_en,
  output logic              rate_evt
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  phase_q;
  logic [CNT_W-1:0]  phase_nx;
  logic [CNT_W-1:0]  low_mask;
  logic [CODE_W-1:0] shift_amt;
  logic              hit;

  assign phase_nx  = phase_q + 1'b1;
  assign shift_amt = rate_sel - 1'b1;
  assign low_mask  = ~(ALL_ONES << shift_amt);
  assign hit       = rate_en && (rate_sel != '0) && ((phase_nx & low_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      rate_evt <= 1'b0;
    end else begin
      rate_evt <= tick_32k & hit;
      if (tick_32k) phase_q <= phase_nx;
    end
  end

endmodule

// File: rtl/periodic_rate_gen_chk.sv
`timescale 1ns/1ps
module periodic_rate_gen_chk #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_32k,
  input logic [CODE_W-1:0] rate_sel,
  input logic              rate_en,
  input logic              rate_evt,
  input logic [CNT_W-1:0]  phase_q
);

  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CODE_W-1:0] sel_d;
  logic [CNT_W-1:0]  period_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_d <= '0;
    else        sel_d <= rate_sel;
  end

  always_comb begin
    if (sel_d == '0) period_m1 = '0;
    else             period_m1 = (ONE << (sel_d - 1'b1)) - ONE;
  end

  a_r5_evt_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rate_evt |-> $past(tick_32k));

  a_r2_zero_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rate_evt |-> ($past(rate_sel) != '0));

  a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    rate_evt |-> $past(rate_en));

  a_r4_phase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rate_evt |-> ((phase_q & period_m1) == '0));

  a_r9_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_32k |=> (phase_q == CNT_W'($past(phase_q) + 1)));

  a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_32k |=> $stable(phase_q));

endmodule

bind periodic_rate_gen periodic_rate_gen_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
  .rate_en(rate_en), .rate_evt(rate_evt), .phase_q(phase_q)
);

// File: tb/periodic_rate_gen_tb.sv
`timescale 1ns/1ps
module periodic_rate_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       rate_en = 1'b0;
  logic       rate_evt;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int mphase = 0;

  bit    q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  periodic_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
    .rate_sel(rate_sel), .rate_en(rate_en), .rate_evt(rate_evt)
  );

  task automatic drive_cycle(input bit t, input logic [3:0] c, input bit e, input string tag);
    bit exp;
    @(negedge clk);
    tick_32k = t;
    rate_sel = c;
    rate_en  = e;
    exp = 1'b0;
    if (t) begin
      mphase = (mphase + 1) % 32768;
      if (e && c != 0) exp = ((mphase % (1 << (c - 1))) == 0);
    end
    q_exp.push_back(exp);
    q_tag.push_back(t ? tag : "R5");
  endtask

  task automatic run_ticks(input int n, input logic [3:0] c, input bit e, input string tag);
    for (int i = 0; i < n; i++) begin
      drive_cycle(1'b1, c, e, tag);
      drive_cycle(1'b0, c, e, tag);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      bit    e;
      string tg;
      e  = q_exp.pop_front();
      tg = q_tag.pop_front();
      total++;
      if (rate_evt !== e) begin
        bad++;
        $display("FAIL %s: rate_evt=%0b expected=%0b at phase model %0d", tg, rate_evt, e, mphase);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (rate_evt !== 1'b0) begin
      bad++;
      $display("FAIL R1: rate_evt=%0b expected=0 during reset", rate_evt);
    end
    rst_n = 1'b1;
    total++;
    if (rate_evt !== 1'b0) begin
      bad++;
      $display("FAIL R1: rate_evt=%0b expected=0 after reset", rate_evt);
    end
    run_ticks(40, 4'd4, 1'b1, "R1");
    run_ticks(50, 4'd0, 1'b1, "R2");
    run_ticks(50, 4'd3, 1'b0, "R3");
    run_ticks(20, 4'd1, 1'b1, "R8");
    run_ticks(3,  4'd5, 1'b0, "R6");
    run_ticks(70, 4'd5, 1'b1, "R6");
    run_ticks(37, 4'd6, 1'b1, "R7");
    run_ticks(11, 4'd2, 1'b1, "R7");
    run_ticks(5,  4'd3, 1'b0, "R7");
    run_ticks(9,  4'd3, 1'b1, "R7");
    run_ticks(33000, 4'd15, 1'b1, "R9");
    run_ticks(30, 4'd4, 1'b1, "R4");
    @(posedge clk);
    #2;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #950000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule